// File: doc/BRIEF.md
# UART Receive Buffer with Fill-Level Interrupts

This block sits on the receive side of a memory-mapped UART, between the serial deserialiser and the register interface. Bytes arrive either from the serial line or, when loopback is selected, from the transmit path. They are held in a small ring buffer. A register read pops the oldest byte, which is returned together with a sticky 4-bit error status. The buffer runs in one of two modes. In FIFO mode it holds 16 entries. In character mode it is a single holding register. Any change of mode discards everything buffered.

Two raw interrupt bits are produced. The level bit fires when the fill count climbs past a programmable threshold, set as a fraction of the depth. The timeout bit stays high for as long as unread data remains. Flag outputs show full and empty for the receiver. The transmitter is reported as always empty, because transmission is immediate at this level.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is empty, both interrupt bits and the overrun flag are 0, and character mode (depth 1) is in effect.
- R2: With the mode input at 1 the buffer holds 16 bytes and returns them in arrival order.
- R3: With the mode input at 0 the buffer holds one byte, and the count never exceeds 1.
- R4: Any change of the mode input empties the buffer one cycle later and clears both interrupt bits. A push or pop in that cycle is ignored; the status clear still applies.
- R5: Threshold select 0..4 gives 2, 4, 8, 12 or 14 entries in FIFO mode, and 5..7 gives 16. In character mode the threshold is 1.
- R6: The level interrupt is set only by an accepted push that moves the count from below the threshold to at or above it. Lowering the threshold while the count is already above it does not set the bit.
- R7: The level interrupt is cleared by a pop that leaves the count below the threshold.
- R8: The timeout interrupt is set by any push attempt that leaves the buffer non-empty. It is cleared by a pop that empties the buffer, and it is never high while the buffer is empty.
- R9: A push into a full buffer with no pop in the same cycle drops the byte and sets the sticky overrun status bit (bit 3). A pop does not clear that bit; the status clear input does.
- R10: The read word carries the oldest byte in bits [7:0], or 0 when empty, and the status in bits [11:8]. Bit 0 is framing, bit 1 is parity and bit 2 is break. These bits are sticky from serial pushes, and a pop clears them.
- R11: The full flag is 1 when the count equals the current depth, and the empty flag is 1 when the count is 0. The transmit-empty output is always 1.
- R12: While loopback is selected only the loopback strobe and byte are taken, and the serial strobe and error bits are ignored.
- R13: A simultaneous push and pop on a non-empty buffer keeps the count unchanged, including when it is full. The interrupt rules are applied to the resulting count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_push_i | input | 1 | Serial-side byte strobe |
| ser_byte_i | input | BYTE_W | Serial-side byte |
| ser_err_i | input | 3 | Serial errors {break, parity, framing} with the strobe |
| lb_sel_i | input | 1 | Take bytes from the loopback path |
| lb_push_i | input | 1 | Loopback byte strobe |
| lb_byte_i | input | BYTE_W | Loopback byte |
| pop_i | input | 1 | Data-register read strobe |
| fifo_en_i | input | 1 | 1 selects FIFO mode, 0 selects character mode |
| thr_sel_i | input | 3 | Threshold select |
| stat_clr_i | input | 1 | Clear all status bits |
| rd_word_o | output | BYTE_W+4 | {status, oldest byte} |
| rx_full_o | output | 1 | Receive full |
| rx_empty_o | output | 1 | Receive empty |
| tx_empty_o | output | 1 | Transmit empty, constant 1 |
| rx_lvl_irq_o | output | 1 | Raw receive-level interrupt |
| rx_tmo_irq_o | output | 1 | Raw receive-timeout interrupt |
| overrun_o | output | 1 | Sticky overrun status |

## Verification
The hardest case to reach is a threshold change while the count sits above the new threshold. The level bit must then stay low until a pop takes the count below the threshold and a later push crosses it again. The directed part of the bench does this on purpose. It fills to ten entries under a high threshold and then drops the select. It also pairs a push with a pop at the threshold and at full depth. The random part toggles the mode input while the buffer is partly full and mixes pushes, pops and threshold changes. This covers flushes from arbitrary fill levels.

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
  parameter int DEPTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_push_i,
  input  logic [BYTE_W-1:0] ser_byte_i,
  input  logic [2:0]        ser_err_i,
  input  logic              lb_sel_i,
  input  logic              lb_push_i,
  input  logic [BYTE_W-1:0] lb_byte_i,
  input  logic              pop_i,
  input  logic              fifo_en_i,
  input  logic [2:0]        thr_sel_i,
  input  logic              stat_clr_i,
  output logic [BYTE_W+3:0] rd_word_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic              tx_empty_o,
  output logic              rx_lvl_irq_o,
  output logic              rx_tmo_irq_o,
  output logic              overrun_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt, cnt_nx, depth_eff, thr;
  logic              fen_q, lvl_q, tmo_q;
  logic [3:0]        stat_q, stat_nx;

  logic              flush, push_w, push_ok, pop_ok, drop;
  logic [BYTE_W-1:0] byte_w;
  logic [2:0]        err_w;

  assign flush  = fifo_en_i != fen_q;
  assign push_w = lb_sel_i ? lb_push_i : ser_push_i;
  assign byte_w = lb_sel_i ? lb_byte_i : ser_byte_i;
  assign err_w  = lb_sel_i ? 3'b000 : ser_err_i;

  assign depth_eff = fen_q ? CW'(DEPTH) : CW'(1);

  always_comb begin
    if (!fen_q) thr = CW'(1);
    else begin
      case (thr_sel_i)
        3'd0:    thr = CW'(DEPTH / 8);
        3'd1:    thr = CW'(DEPTH / 4);
        3'd2:    thr = CW'(DEPTH / 2);
        3'd3:    thr = CW'(DEPTH * 3 / 4);
        3'd4:    thr = CW'(DEPTH * 7 / 8);
        default: thr = CW'(DEPTH);
      endcase
    end
  end

  assign pop_ok  = pop_i && (cnt != '0) && !flush;
  assign push_ok = push_w && !flush && ((cnt != depth_eff) || pop_ok);
  assign drop    = push_w && !flush && !push_ok;
  assign cnt_nx  = cnt + CW'(push_ok) - CW'(pop_ok);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p, input logic [CW-1:0] d);
    return (p == AW'(d - CW'(1))) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    stat_nx = stat_q;
    if (stat_clr_i) stat_nx = '0;
    else if (pop_ok) stat_nx = {stat_q[3], 3'b000};
    if (!flush) begin
      if (push_w) stat_nx[2:0] = stat_nx[2:0] | err_w;
      if (drop)   stat_nx[3]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= byte_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fen_q  <= 1'b0;
      cnt    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      lvl_q  <= 1'b0;
      tmo_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_nx;
      if (flush) begin
        fen_q  <= fifo_en_i;
        cnt    <= '0;
        wr_ptr <= '0;
        rd_ptr <= '0;
        lvl_q  <= 1'b0;
        tmo_q  <= 1'b0;
      end else begin
        cnt <= cnt_nx;
        if (push_ok) wr_ptr <= ptr_inc(wr_ptr, depth_eff);
        if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr, depth_eff);
        if (pop_ok && cnt_nx < thr) lvl_q <= 1'b0;
        else if (push_ok && cnt < thr && cnt_nx >= thr) lvl_q <= 1'b1;
        if (push_w && cnt_nx != '0) tmo_q <= 1'b1;
        else if (pop_ok && cnt_nx == '0) tmo_q <= 1'b0;
      end
    end
  end

  assign rd_word_o    = {stat_q, (cnt == '0) ? BYTE_W'(0) : mem[rd_ptr]};
  assign rx_full_o    = cnt == depth_eff;
  assign rx_empty_o   = cnt == '0;
  assign tx_empty_o   = 1'b1;
  assign rx_lvl_irq_o = lvl_q;
  assign rx_tmo_irq_o = tmo_q;
  assign overrun_o    = stat_q[3];

  // R3
  char_mode_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fen_q |-> cnt <= CW'(1));

  // R4
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rx_empty_o && !rx_lvl_irq_o && !rx_tmo_irq_o));

  // R6
  lvl_rise_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_lvl_irq_o) |-> $past(push_ok));

  // R8
  tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tmo_irq_o |-> !rx_empty_o);

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(drop));

endmodule

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_push, lb_sel, lb_push, pop, fen, clr;
  logic [7:0] ser_byte, lb_byte;
  logic [2:0] ser_err, thr_sel;
  logic [11:0] rd_word;
  logic full, empty, tx_empty, lvl, tmo, ovr;

  int n_cmp = 0, n_bad = 0;

  logic [7:0] mq [16];
  int mcnt;
  logic mfen, mlvl, mtmo;
  logic [3:0] mstat;

  always #(CLK_P/2) clk = ~clk;

  uart_rx_buffer u_uart_rx_buffer (
    .clk(clk), .rst_n(rst_n),
    .ser_push_i(ser_push), .ser_byte_i(ser_byte), .ser_err_i(ser_err),
    .lb_sel_i(lb_sel), .lb_push_i(lb_push), .lb_byte_i(lb_byte),
    .pop_i(pop), .fifo_en_i(fen), .thr_sel_i(thr_sel), .stat_clr_i(clr),
    .rd_word_o(rd_word), .rx_full_o(full), .rx_empty_o(empty),
    .tx_empty_o(tx_empty), .rx_lvl_irq_o(lvl), .rx_tmo_irq_o(tmo),
    .overrun_o(ovr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int thr_of(input logic f, input logic [2:0] s);
    if (!f) return 1;
    case (s)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      3'd4: return 14;
      default: return 16;
    endcase
  endfunction

  task automatic model_step();
    logic p, popv, acc, drp;
    logic [7:0] b;
    logic [2:0] e;
    int depth, t, old_c;
    if (fen != mfen) begin
      if (clr) mstat = '0;
      mcnt = 0; mlvl = 0; mtmo = 0; mfen = fen;
      return;
    end
    p = lb_sel ? lb_push : ser_push;
    b = lb_sel ? lb_byte : ser_byte;
    e = lb_sel ? 3'b000 : ser_err;
    depth = mfen ? 16 : 1;
    t = thr_of(mfen, thr_sel);
    popv = pop && mcnt > 0;
    acc = p && (mcnt < depth || popv);
    drp = p && !acc;
    old_c = mcnt;
    if (clr) mstat = '0;
    else if (popv) mstat = {mstat[3], 3'b000};
    if (p) mstat[2:0] = mstat[2:0] | e;
    if (drp) mstat[3] = 1'b1;
    if (popv) begin
      for (int i = 0; i < 15; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (acc) begin
      mq[mcnt] = b;
      mcnt++;
    end
    if (popv && mcnt < t) mlvl = 0;
    else if (acc && old_c < t && mcnt >= t) mlvl = 1;
    if (p && mcnt != 0) mtmo = 1;
    else if (popv && mcnt == 0) mtmo = 0;
  endtask

  task automatic compare_all();
    chk("R10", 32'(rd_word), 32'({mstat, (mcnt != 0) ? mq[0] : 8'h00}));
    chk("R11", 32'(full), 32'(mcnt == (mfen ? 16 : 1)));
    chk("R11", 32'(empty), 32'(mcnt == 0));
    chk("R11", 32'(tx_empty), 32'd1);
    chk("R6", 32'(lvl), 32'(mlvl));
    chk("R8", 32'(tmo), 32'(mtmo));
    chk("R9", 32'(ovr), 32'(mstat[3]));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    ser_push = 0; lb_push = 0; pop = 0; clr = 0; lb_sel = 0;
    ser_err = 0; ser_byte = 0; lb_byte = 0;
  endtask

  task automatic push_b(input logic [7:0] b);
    idle(); ser_push = 1; ser_byte = b; tick();
  endtask

  task automatic pop1();
    idle(); pop = 1; tick();
  endtask

  task automatic set_mode(input logic f);
    idle(); fen = f; tick();
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); fen = 0; thr_sel = 0;
    mcnt = 0; mfen = 0; mlvl = 0; mtmo = 0; mstat = 0;
    for (int i = 0; i < 16; i++) mq[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", 32'(empty), 32'd1);
    chk("R1", 32'(full), 32'd0);
    chk("R1", 32'({lvl, tmo, ovr}), 32'd0);
    compare_all();

    // R3 one entry holds, second push dropped -> R9 overrun
    push_b(8'hA1);
    chk("R3", 32'(full), 32'd1);
    chk("R8", 32'(tmo), 32'd1);
    chk("R5", 32'(lvl), 32'd1);
    idle(); ser_push = 1; ser_byte = 8'hB2; ser_err = 3'b101; tick();
    chk("R9", 32'(ovr), 32'd1);
    chk("R10", 32'(rd_word), 32'hDA1);
    pop1();
    chk("R10", 32'(rd_word), 32'h800);
    chk("R8", 32'(tmo), 32'd0);
    chk("R7", 32'(lvl), 32'd0);
    idle(); clr = 1; tick();
    chk("R9", 32'(ovr), 32'd0);

    // R4 mode change flushes; push in that cycle ignored
    push_b(8'h11);
    idle(); fen = 1; ser_push = 1; ser_byte = 8'h22; tick();
    chk("R4", 32'(empty), 32'd1);
    chk("R4", 32'({lvl, tmo}), 32'd0);

    // R2 depth 16 and order
    for (int i = 0; i < 16; i++) push_b(8'(8'h40 + i));
    chk("R2", 32'(full), 32'd1);
    // R13 push + pop while full
    idle(); ser_push = 1; ser_byte = 8'h7E; pop = 1; tick();
    chk("R13", 32'(full), 32'd1);
    chk("R9", 32'(ovr), 32'd0);
    for (int i = 1; i < 16; i++) begin
      chk("R2", 32'(rd_word[7:0]), 32'(8'h40 + i));
      pop1();
    end
    chk("R2", 32'(rd_word[7:0]), 32'h7E);
    pop1();

    // R5/R6 threshold table, crossing exactly at threshold
    for (int s = 0; s < 8; s++) begin
      set_mode(0); set_mode(1);
      thr_sel = 3'(s);
      for (int k = 1; k <= 16; k++) begin
        push_b(8'(k));
        chk("R5", 32'(lvl), 32'(k >= thr_of(1'b1, 3'(s))));
      end
    end

    // R6 lowering threshold above count does not set; R7 clear; R13 at threshold
    set_mode(0); set_mode(1);
    thr_sel = 3;
    for (int k = 0; k < 10; k++) push_b(8'(k));
    thr_sel = 0; idle(); tick();
    chk("R6", 32'(lvl), 32'd0);
    push_b(8'hEE);
    chk("R6", 32'(lvl), 32'd0);
    for (int k = 0; k < 10; k++) pop1();
    chk("R7", 32'(lvl), 32'd0);
    push_b(8'h01);
    chk("R6", 32'(lvl), 32'd1);
    idle(); ser_push = 1; ser_byte = 8'h02; pop = 1; tick();
    chk("R13", 32'(lvl), 32'd1);
    chk("R13", 32'(empty), 32'd0);
    pop1();
    chk("R7", 32'(lvl), 32'd0);
    chk("R8", 32'(tmo), 32'd1);
    pop1();
    chk("R8", 32'(tmo), 32'd0);

    // R12 loopback source
    idle(); lb_sel = 1; ser_push = 1; ser_byte = 8'h55; ser_err = 3'b111; tick();
    chk("R12", 32'(empty), 32'd1);
    chk("R12", 32'(rd_word[10:8]), 32'd0);
    idle(); lb_sel = 1; lb_push = 1; lb_byte = 8'h9C; ser_err = 3'b011; tick();
    chk("R12", 32'(rd_word), 32'h09C);
    // R10 error bits cleared by pop
    idle(); ser_push = 1; ser_byte = 8'h33; ser_err = 3'b010; tick();
    chk("R10", 32'(rd_word), 32'h29C);
    pop1();
    chk("R10", 32'(rd_word), 32'h033);
    pop1();

    // random phase
    for (int n = 0; n < 6000; n++) begin
      idle();
      lb_sel   = ($urandom_range(0, 7) == 0);
      ser_push = ($urandom_range(0, 2) != 0);
      lb_push  = ($urandom_range(0, 1) != 0);
      ser_byte = 8'($urandom);
      lb_byte  = 8'($urandom);
      ser_err  = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b000;
      pop      = ($urandom_range(0, 2) != 0);
      clr      = ($urandom_range(0, 60) == 0);
      if ($urandom_range(0, 150) == 0) fen = ~fen;
      if ($urandom_range(0, 40) == 0) thr_sel = 3'($urandom);
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule